// File: doc/BRIEF.md
# Front-End Readout Timing Emulator

This block is a digital stand-in for the timing behaviour of a remote front-end readout chip. It runs on the same reset, 40 MHz sampling clock and level-0 accept strobe that the chip receives. It tracks the chip's pipeline cell pointer and the queue of accepted events that wait for readout. From these it predicts when each event frame will reach the receiving side of the data links. The receiving logic can therefore locate frame headers without searching the incoming data for them.

Every accepted event records the pipeline cell that was current when the accept was sampled. Events wait in a first-in first-out queue whose usable depth is selected by a mode input. They are then sent out as frames of 34 slots each: two header slots, then 32 sample slots. A programmable link delay, loaded over a one-cycle write strobe, moves the predicted frame timing later so that it lines up with the arrival of the real data. The outputs are a header strobe, a sample-slot strobe, the predicted pipeline identifier, and a count of accepts that were lost because the queue was full.

Top module: `fetime_emu`

## Requirements
- R1: While reset is asserted, hdr_valid, smp_valid, pred_pid and ovf_count are all 0, the link delay returns to 4, and the cell pointer returns to cell 0. An accept sampled on the first clock edge after reset is released therefore carries identifier 0.
- R2: The cell pointer advances by one on every clock edge and wraps from 127 to 0. The predicted identifier of an event is the pointer value at the edge where its accept was sampled, zero-extended to 8 bits.
- R3: An accept that arrives while the queue already holds its full capacity is dropped and produces no frame. ovf_count then rises by one, saturating at its maximum value.
- R4: With deep_mode = 1 the queue holds up to 16 events. With deep_mode = 0 it holds up to 8.
- R5: Every frame raises hdr_valid for exactly its first two slots. During those two slots pred_pid shows the event's identifier; at all other times pred_pid is 0.
- R6: smp_valid is high for the 32 slots that follow the header. When the queue is empty after a frame ends, both strobes stay low.
- R7: With the link delay at 0 and no frame in progress, an accept sampled at edge k makes hdr_valid high in the cycle that follows edge k+1.
- R8: When events are waiting, the next frame begins in the slot right after the 34th slot of the current frame, with no idle slot in between.
- R9: A pulse on dly_we loads dly_wdata into the link delay. Both strobes and pred_pid then appear exactly that many cycles after their zero-delay timing, for any value from 0 to 63.
- R10: Frames come out in the same order in which their accepts were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz sampling clock shared with the front-end chip |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_acc | input | 1 | Level-0 accept strobe, sampled on each rising clock edge |
| deep_mode | input | 1 | Queue capacity select: 1 gives 16 events, 0 gives 8 |
| dly_we | input | 1 | Write strobe for the link delay register |
| dly_wdata | input | 6 | New link delay value, in clock cycles |
| hdr_valid | output | 1 | Predicted header slot on the receiving side |
| smp_valid | output | 1 | Predicted sample slot on the receiving side |
| pred_pid | output | 8 | Predicted pipeline identifier, valid while hdr_valid is high |
| ovf_count | output | 16 | Number of accepts dropped because the queue was full (saturating) |

## Verification
A wrong pointer value shows up on pred_pid at the next header after the affected accept. It stays wrong for every later event, because the pointer never resynchronises. A queue occupancy that is off by one shows up in two ways. It changes ovf_count during a long burst of accepts. It also lets an extra frame through, or holds one back, which shifts every later header by a full 34 slots. A fault in the slot counter or in the delay tap is visible within one frame, as a header pulse that is too long, too short or misplaced. The reference model compares all four outputs on every clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/fetime_pkg.sv
package fetime_pkg;

  localparam int PID_W = 8;

  // One slot of predicted link timing, as carried through the delay line
  typedef struct packed {
    logic             hdr;
    logic             smp;
    logic [PID_W-1:0] pid;
  } slot_t;

  // Modulo increment used for wrapping pointers and counters
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction

  // Usable queue depth for the selected mode
  function automatic int unsigned queue_cap(input logic deep, input int unsigned deep_n,
                                            input int unsigned shallow_n);
    return deep ? deep_n : shallow_n;
  endfunction

endpackage

// File: rtl/fetime_cellptr.sv
module fetime_cellptr #(
  parameter int CELLS = 128,
  localparam int PW = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ptr_o
);
  import fetime_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_o <= '0;
    else        ptr_o <= PW'(wrap_inc(int'(ptr_o), CELLS));
  end
endmodule

// File: rtl/fetime_derand.sv
module fetime_derand #(
  parameter int DEPTH   = 16,
  parameter int SHALLOW = 8,
  parameter int DW      = 7,
  parameter int OVF_W   = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_i,
  input  logic          push_req_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [AW:0]   cnt_o,
  output logic [AW:0]   cap_o,
  output logic          push_o,
  output logic          drop_o,
  output logic [OVF_W-1:0] ovf_o
);
  import fetime_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_pop;

  assign cap_o  = (AW+1)'(queue_cap(deep_i, DEPTH, SHALLOW));
  assign full   = (cnt_o >= cap_o);
  assign push_o = push_req_i && !full;
  assign drop_o = push_req_i && full;
  assign do_pop = pop_i && (cnt_o != '0);
  assign head_o = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_o) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_o) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (do_pop) rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      case ({push_o, do_pop})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf_o <= '0;
    else if (drop_o && ovf_o != '1)   ovf_o <= ovf_o + 1'b1;
  end
endmodule

// File: rtl/fetime_framer.sv
module fetime_framer #(
  parameter int SLOTS     = 34,
  parameter int HDR_SLOTS = 2,
  parameter int DW        = 7,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail_i,
  input  logic [DW-1:0] head_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          last_o,
  output logic          hdr_o,
  output logic          smp_o,
  output logic [DW-1:0] pid_o
);
  logic [SW-1:0] slot;

  assign last_o = busy_o && (slot == SW'(SLOTS-1));
  assign pop_o  = avail_i && (!busy_o || last_o);
  assign hdr_o  = busy_o && (slot <  SW'(HDR_SLOTS));
  assign smp_o  = busy_o && (slot >= SW'(HDR_SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      slot   <= '0;
      pid_o  <= '0;
    end else if (pop_o) begin
      busy_o <= 1'b1;
      slot   <= '0;
      pid_o  <= head_i;
    end else if (last_o) begin
      busy_o <= 1'b0;
      slot   <= '0;
    end else if (busy_o) begin
      slot   <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/fetime_linkdly.sv
module fetime_linkdly #(
  parameter int DLY_W = 6,
  parameter int W     = 10,
  localparam int MAXD = (1 << DLY_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] taps [MAXD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps[0] <= '0;
    else        taps[0] <= d_i;
  end

  for (genvar g = 1; g < MAXD; g++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[g] <= '0;
      else        taps[g] <= taps[g-1];
    end
  end

  assign q_o = (dly_i == '0) ? d_i : taps[dly_i - 1'b1];
endmodule

// File: rtl/fetime_emu.sv
module fetime_emu #(
  parameter int CELLS     = 128,
  parameter int DEPTH     = 16,
  parameter int SHALLOW   = 8,
  parameter int SLOTS     = 34,
  parameter int HDR_SLOTS = 2,
  parameter int DLY_W     = 6,
  parameter int DLY_RST   = 4,
  parameter int OVF_W     = 16,
  localparam int PID_W = fetime_pkg::PID_W,
  localparam int PW    = $clog2(CELLS),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             l0_acc,
  input  logic             deep_mode,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_wdata,
  output logic             hdr_valid,
  output logic             smp_valid,
  output logic [PID_W-1:0] pred_pid,
  output logic [OVF_W-1:0] ovf_count
);
  import fetime_pkg::*;

  // Named internal events, also observed by the bound checker
  logic [PW-1:0]    cell_ptr;
  logic [PW-1:0]    fifo_head;
  logic [AW:0]      fifo_cnt, fifo_cap;
  logic             push_evt, drop_evt, pop_evt;
  logic             frm_busy, frm_last;
  logic             chip_hdr, chip_smp;
  logic [PW-1:0]    chip_pid;
  logic [DLY_W-1:0] link_dly;
  slot_t            near_slot, far_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      link_dly <= DLY_W'(DLY_RST);
    else if (dly_we) link_dly <= dly_wdata;
  end

  fetime_cellptr #(.CELLS(CELLS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ptr_o(cell_ptr)
  );

  fetime_derand #(.DEPTH(DEPTH), .SHALLOW(SHALLOW), .DW(PW), .OVF_W(OVF_W)) u_derand (
    .clk(clk), .rst_n(rst_n), .deep_i(deep_mode),
    .push_req_i(l0_acc), .data_i(cell_ptr), .pop_i(pop_evt),
    .head_o(fifo_head), .cnt_o(fifo_cnt), .cap_o(fifo_cap),
    .push_o(push_evt), .drop_o(drop_evt), .ovf_o(ovf_count)
  );

  fetime_framer #(.SLOTS(SLOTS), .HDR_SLOTS(HDR_SLOTS), .DW(PW)) u_framer (
    .clk(clk), .rst_n(rst_n), .avail_i(fifo_cnt != '0), .head_i(fifo_head),
    .pop_o(pop_evt), .busy_o(frm_busy), .last_o(frm_last),
    .hdr_o(chip_hdr), .smp_o(chip_smp), .pid_o(chip_pid)
  );

  always_comb begin
    near_slot.hdr = chip_hdr;
    near_slot.smp = chip_smp;
    near_slot.pid = chip_hdr ? PID_W'(chip_pid) : '0;
  end

  fetime_linkdly #(.DLY_W(DLY_W), .W($bits(slot_t))) u_dly (
    .clk(clk), .rst_n(rst_n), .d_i(near_slot), .dly_i(link_dly), .q_o(far_slot)
  );

  assign hdr_valid = far_slot.hdr;
  assign smp_valid = far_slot.smp;
  assign pred_pid  = far_slot.pid;
endmodule

// File: rtl/fetime_emu_chk.sv
module fetime_emu_chk #(
  parameter int CELLS = 128,
  parameter int DEPTH = 16,
  parameter int OVF_W = 16,
  localparam int PW = $clog2(CELLS),
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PW-1:0]    cell_ptr,
  input logic [AW:0]      fifo_cnt,
  input logic [AW:0]      fifo_cap,
  input logic             push_evt,
  input logic             drop_evt,
  input logic             frm_last,
  input logic             chip_hdr,
  input logic             chip_smp,
  input logic [PW-1:0]    chip_pid,
  input logic [OVF_W-1:0] ovf_count
);
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cell_ptr == PW'((int'($past(cell_ptr)) + 1) % CELLS)));

  p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt >= fifo_cap) |-> !push_evt);

  p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && ovf_count != '1) |=> (ovf_count == $past(ovf_count) + 1'b1));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= (AW+1)'(DEPTH));

  p_hdr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_hdr) |=> chip_hdr);

  p_hdr_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_hdr && $past(chip_hdr)) |=> !chip_hdr);

  p_smp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_hdr) |-> chip_smp);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_last && fifo_cnt == '0) |=> (!chip_hdr && !chip_smp));

  p_back2back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_last && fifo_cnt != '0) |=> chip_hdr);

  p_pid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_hdr && $past(chip_hdr)) |-> $stable(chip_pid));
endmodule

bind fetime_emu fetime_emu_chk #(.CELLS(CELLS), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_ptr(cell_ptr), .fifo_cnt(fifo_cnt),
  .fifo_cap(fifo_cap), .push_evt(push_evt), .drop_evt(drop_evt),
  .frm_last(frm_last), .chip_hdr(chip_hdr), .chip_smp(chip_smp),
  .chip_pid(chip_pid), .ovf_count(ovf_count)
);

// File: tb/fetime_emu_tb.sv
`timescale 1ns/1ps
module fetime_emu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l0_acc = 1'b0;
  logic       deep_mode = 1'b1;
  logic       dly_we = 1'b0;
  logic [5:0] dly_wdata = '0;
  logic       hdr_valid, smp_valid;
  logic [7:0] pred_pid;
  logic [15:0] ovf_count;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  fetime_emu u_dut (
    .clk(clk), .rst_n(rst_n), .l0_acc(l0_acc), .deep_mode(deep_mode),
    .dly_we(dly_we), .dly_wdata(dly_wdata), .hdr_valid(hdr_valid),
    .smp_valid(smp_valid), .pred_pid(pred_pid), .ovf_count(ovf_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int q[$];
  bit m_act = 0;
  int m_slot = 0, m_cur = 0, m_ptr = 0, m_ovf = 0, m_dly = 4, cyc = 0;
  bit h_hdr [128];
  bit h_smp [128];
  int h_pid [128];

  initial begin
    for (int i = 0; i < 128; i++) begin h_hdr[i] = 0; h_smp[i] = 0; h_pid[i] = 0; end
  end

  always @(posedge clk) begin
    bit full;
    cyc++;
    if (!rst_n) begin
      q.delete(); m_act = 0; m_slot = 0; m_cur = 0; m_ptr = 0; m_ovf = 0; m_dly = 4;
    end else begin
      full = q.size() >= (deep_mode ? 16 : 8);
      if ((!m_act || m_slot == 33) && q.size() > 0) begin
        m_cur = q.pop_front(); m_act = 1; m_slot = 0;
      end else if (m_act) begin
        if (m_slot == 33) m_act = 0; else m_slot++;
      end
      if (l0_acc) begin
        if (!full) q.push_back(m_ptr);
        else if (m_ovf < 65535) m_ovf++;
      end
      m_ptr = (m_ptr + 1) % 128;
      if (dly_we) m_dly = int'(dly_wdata);
    end
    h_hdr[cyc % 128] = m_act && m_slot < 2;
    h_smp[cyc % 128] = m_act && m_slot >= 2;
    h_pid[cyc % 128] = (m_act && m_slot < 2) ? m_cur : 0;
  end

  // Full comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    int ix;
    if (rst_n) begin
      ix = (((cyc - m_dly) % 128) + 128) % 128;
      check(hdr_valid == h_hdr[ix], "R5 R7 R8 R9 hdr_valid", int'(hdr_valid), int'(h_hdr[ix]));
      check(smp_valid == h_smp[ix], "R6 R9 smp_valid", int'(smp_valid), int'(h_smp[ix]));
      check(int'(pred_pid) == h_pid[ix], "R2 R10 pred_pid", int'(pred_pid), h_pid[ix]);
      check(int'(ovf_count) == m_ovf, "R3 ovf_count", int'(ovf_count), m_ovf);
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_delay(input int d);
    @(negedge clk); dly_we = 1'b1; dly_wdata = 6'(d);
    @(negedge clk); dly_we = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic latency(input int d, input string req, output int pid_seen);
    int w = 0;
    bit seen = 0;
    pid_seen = -1;
    @(negedge clk); l0_acc = 1'b1;
    @(negedge clk); l0_acc = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk); w++;
      if (hdr_valid) begin seen = 1; pid_seen = int'(pred_pid); end
    end
    check(w == 1 + d, req, w, 1 + d);
    repeat (120) @(negedge clk);
  endtask

  task automatic burst(input int n);
    @(negedge clk); l0_acc = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); l0_acc = 1'b0;
    repeat (20 * 34 + 100) @(negedge clk);
  endtask

  initial begin
    int p, o0;
    repeat (5) @(negedge clk);
    // R1: outputs during reset
    check(hdr_valid == 1'b0, "R1 hdr_valid in reset", int'(hdr_valid), 0);
    check(smp_valid == 1'b0, "R1 smp_valid in reset", int'(smp_valid), 0);
    check(pred_pid == 8'd0, "R1 pred_pid in reset", int'(pred_pid), 0);
    check(ovf_count == 16'd0, "R1 ovf_count in reset", int'(ovf_count), 0);
    rst_n = 1'b1;
    // R1: accept on first edge after reset carries cell 0, default delay 4
    l0_acc = 1'b1;
    @(negedge clk); l0_acc = 1'b0;
    begin
      int w = 0;
      bit seen = 0;
      for (int i = 0; i < 100 && !seen; i++) begin
        @(negedge clk); w++;
        if (hdr_valid) seen = 1;
      end
      check(w == 5, "R1 R9 default delay latency", w, 5);
      check(pred_pid == 8'd0, "R1 R2 first identifier", int'(pred_pid), 0);
    end
    repeat (100) @(negedge clk);

    // R7: zero delay
    set_delay(0);
    latency(0, "R7 zero-delay latency", p);
    // R9: other delays
    set_delay(9);
    latency(9, "R9 delay 9 latency", p);
    set_delay(63);
    latency(63, "R9 delay 63 latency", p);
    set_delay(2);

    // R4 / R3: shallow capacity burst of 20 -> 11 dropped
    deep_mode = 1'b0;
    o0 = int'(ovf_count);
    burst(20);
    check(int'(ovf_count) - o0 == 11, "R3 R4 shallow drops", int'(ovf_count) - o0, 11);
    // R4: deep capacity burst of 20 -> 3 dropped
    deep_mode = 1'b1;
    o0 = int'(ovf_count);
    burst(20);
    check(int'(ovf_count) - o0 == 3, "R4 deep drops", int'(ovf_count) - o0, 3);

    // R8 R10: random traffic, mixed modes
    for (int ph = 0; ph < 4; ph++) begin
      deep_mode = ph[0];
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        l0_acc = ($urandom_range(0, 29) == 0);
      end
      @(negedge clk); l0_acc = 1'b0;
      repeat (17 * 34 + 80) @(negedge clk);
      if (ph == 1) set_delay(17);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule